// File: doc/BRIEF.md
# Per-Channel Over-Scale Flag Generator

This block watches the signed sample words produced for a stereo converter's left and right channels and raises one over-scale flag for each channel. A word counts as over scale when it sits on either rail of its signed range. A flag is raised only after a channel has shown two strobed over-scale words in a row. Once raised, it stays high for a fixed number of left/right clock periods, so that slow monitoring logic or a front-panel indicator can observe it.

Words are evaluated only in cycles where the per-sample strobe is high. Both channels are converted together, so one strobe qualifies both words. The left/right clock is sampled in the block's clock domain, and each of its rising edges counts as one period of the hold time. The digital power-down input forces both flags low and discards all detection state.

Top module: `ovs_flag_gen`

## Requirements
- R1: The left and right flags are independent. Words on one channel never change the flag of the other channel.
- R2: A flag goes high in the cycle after a strobe whose word for that channel is over scale, when the previous strobed word of that channel was also over scale. A single over-scale word does not raise the flag.
- R3: With the default 18-bit words, over scale means exactly 18'h1FFFF (+131071) or 18'h20000 (-131072). Other codes, including 18'h1FFFE and 18'h20001, are in range.
- R4: After a flag is raised, it stays high through 4095 rising edges of the left/right clock. It goes low in the cycle after the 4096th rising edge.
- R5: A new consecutive over-scale pair that arrives while a flag is high reloads the hold time to a full 4096 periods.
- R6: A strobed in-range word clears that channel's consecutive-detection state, so an over-scale word that follows it counts as the first of a new pair.
- R7: While the power-down input is high, both flags are low from the next cycle on, and strobed words are ignored. Detection state is discarded, so after release a single over-scale word does not raise a flag.
- R8: Words presented in cycles without the strobe are not evaluated and do not count toward a pair.
- R9: After the synchronous active-high reset, both flags are low and detection state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Digital power-down, active high |
| smp_stb | input | 1 | One-cycle strobe qualifying both sample words |
| left_word | input | 18 | Left channel signed sample |
| right_word | input | 18 | Right channel signed sample |
| lrck | input | 1 | Left/right clock, synchronous to clk |
| ovs_left | output | 1 | Left over-scale flag |
| ovs_right | output | 1 | Right over-scale flag |

## Verification
The assertions take for granted that the left/right clock is already synchronous to the block clock. They also take for granted that it stays low and high for at least one clock cycle each, so every period shows up as exactly one sampled rising edge. The bench drives this clock from a task that holds it high for one cycle and low for one cycle. The bench changes the strobe, the words and the power-down input only on falling clock edges. It raises the strobe for one cycle per conversion, so every sample is seen exactly once.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    // Consecutive over-scale run seen on one channel
    typedef enum logic [1:0] {
        RUN_NONE = 2'd0,
        RUN_ONE  = 2'd1,
        RUN_PAIR = 2'd2
    } run_e;

    // Per-channel registered state
    typedef struct packed {
        run_e run;
        logic armed;
    } chan_state_t;

    // True when a zero-extended word of the given width sits on either signed rail
    function automatic logic at_rail(input logic [31:0] w, input int unsigned width);
        logic [31:0] neg_code;
        neg_code = 32'd1 << (width - 1);
        return (w == neg_code) || (w == (neg_code - 32'd1));
    endfunction

endpackage

// File: rtl/ovs_edge.sv
module ovs_edge (
    input  logic clk,
    input  logic rst,
    input  logic lrck,
    output logic lr_rise
);
    logic lrck_q;

    always_ff @(posedge clk) begin
        if (rst) lrck_q <= 1'b0;
        else     lrck_q <= lrck;
    end

    assign lr_rise = lrck & ~lrck_q;
endmodule

// File: rtl/ovs_chan.sv
module ovs_chan
    import ovs_pkg::*;
#(
    parameter int unsigned WORD_W = 18,
    parameter int unsigned HOLD   = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              smp_stb,
    input  logic [WORD_W-1:0] word,
    input  logic              lr_rise,
    output logic              flag
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD);

    chan_state_t      st_q, st_d;
    logic [CNT_W-1:0] hold_q, hold_d;
    logic             over, trigger;

    assign over    = at_rail(32'(word), WORD_W);
    assign trigger = smp_stb & over & (st_q.run != RUN_NONE);

    always_comb begin
        st_d   = st_q;
        hold_d = hold_q;
        if (smp_stb) begin
            if (!over)                   st_d.run = RUN_NONE;
            else if (st_q.run == RUN_NONE) st_d.run = RUN_ONE;
            else                         st_d.run = RUN_PAIR;
        end
        if (trigger) begin
            hold_d    = HOLD_LOAD;
            st_d.armed = 1'b1;
        end else if (lr_rise && hold_q != '0) begin
            hold_d = hold_q - CNT_W'(1);
            if (hold_q == CNT_W'(1)) st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            st_q   <= '{run: RUN_NONE, armed: 1'b0};
            hold_q <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
        end
    end

    assign flag = st_q.armed;
endmodule

// File: rtl/ovs_flag_gen.sv
module ovs_flag_gen #(
    parameter int unsigned WORD_W = 18,
    parameter int unsigned HOLD   = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              smp_stb,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    input  logic              lrck,
    output logic              ovs_left,
    output logic              ovs_right
);
    localparam int unsigned N_CH = 2;

    logic              lr_rise;
    logic [WORD_W-1:0] words [N_CH];
    logic [N_CH-1:0]   flags;

    assign words[0] = left_word;
    assign words[1] = right_word;

    ovs_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .lrck    (lrck),
        .lr_rise (lr_rise)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        ovs_chan #(.WORD_W(WORD_W), .HOLD(HOLD)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .pwr_dn  (pwr_dn),
            .smp_stb (smp_stb),
            .word    (words[ch]),
            .lr_rise (lr_rise),
            .flag    (flags[ch])
        );
    end

    assign ovs_left  = flags[0];
    assign ovs_right = flags[1];
endmodule

// File: rtl/ovs_flag_gen_chk.sv
module ovs_flag_gen_chk
    import ovs_pkg::*;
#(
    parameter int unsigned WORD_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_dn,
    input logic              smp_stb,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word,
    input logic              lrck,
    input logic              ovs_left,
    input logic              ovs_right
);
    logic lr_seen, last_l, last_r;
    logic now_l, now_r, lr_up;

    assign now_l = at_rail(32'(left_word), WORD_W);
    assign now_r = at_rail(32'(right_word), WORD_W);
    assign lr_up = lrck & ~lr_seen;

    always_ff @(posedge clk) begin
        if (rst) lr_seen <= 1'b0;
        else     lr_seen <= lrck;
        if (rst || pwr_dn) begin
            last_l <= 1'b0;
            last_r <= 1'b0;
        end else if (smp_stb) begin
            last_l <= now_l;
            last_r <= now_r;
        end
    end

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (!ovs_left && !ovs_right)); // R7

    AST_LEFT_PAIR_SETS: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !pwr_dn && now_l && last_l) |=> ovs_left); // R2

    AST_RIGHT_PAIR_SETS: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !pwr_dn && now_r && last_r) |=> ovs_right); // R1

    AST_LEFT_RISE_STROBED: assert property (@(posedge clk) disable iff (rst)
        $rose(ovs_left) |-> ($past(smp_stb) && !$past(pwr_dn))); // R8

    AST_LEFT_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(ovs_left) |-> ($past(pwr_dn) || $past(lr_up))); // R4

    AST_RIGHT_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(ovs_right) |-> ($past(pwr_dn) || $past(lr_up))); // R4
endmodule

bind ovs_flag_gen ovs_flag_gen_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/ovs_flag_gen_bench.sv
module ovs_flag_gen_bench;
    localparam int W = 18;
    localparam logic [W-1:0] POS  = 18'h1FFFF;
    localparam logic [W-1:0] NEG  = 18'h20000;
    localparam logic [W-1:0] POS1 = 18'h1FFFE;
    localparam logic [W-1:0] NEG1 = 18'h20001;
    localparam logic [W-1:0] MID  = 18'h00123;

    logic clk = 1'b0;
    logic rst = 1'b1, pwr_dn = 1'b0, smp_stb = 1'b0, lrck = 1'b0;
    logic [W-1:0] left_word = '0, right_word = '0;
    logic ovs_left, ovs_right;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    ovs_flag_gen u_ovs_flag_gen (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .smp_stb(smp_stb),
        .left_word(left_word), .right_word(right_word), .lrck(lrck),
        .ovs_left(ovs_left), .ovs_right(ovs_right)
    );

    task automatic expect_flags(input logic el, input logic er, input string req);
        checks++;
        if (ovs_left !== el || ovs_right !== er) begin
            failures++;
            $display("FAIL %s actual=%b%b expected=%b%b", req, ovs_left, ovs_right, el, er);
        end
    endtask

    task automatic sample(input logic [W-1:0] l, input logic [W-1:0] r);
        left_word = l; right_word = r; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0; left_word = MID; right_word = MID;
    endtask

    task automatic lr_tick();
        lrck = 1'b1; @(negedge clk);
        lrck = 1'b0; @(negedge clk);
    endtask

    task automatic clear_all();
        pwr_dn = 1'b1; @(negedge clk);
        pwr_dn = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        expect_flags(1'b0, 1'b0, "R9 reset state");
    endtask

    task automatic t_no_strobe();
        left_word = POS; right_word = NEG;
        repeat (3) @(negedge clk);
        expect_flags(1'b0, 1'b0, "R8 unstrobed words");
        sample(POS, NEG);
        expect_flags(1'b0, 1'b0, "R8 one strobed word after unstrobed ones");
        clear_all();
    endtask

    task automatic t_single_and_break();
        sample(POS, NEG);
        expect_flags(1'b0, 1'b0, "R2 single over-scale word");
        sample(MID, MID);
        sample(POS, NEG);
        expect_flags(1'b0, 1'b0, "R6 in-range word breaks the pair");
        sample(MID, MID);
    endtask

    task automatic t_near_rail();
        sample(POS1, NEG1);
        sample(POS1, NEG1);
        sample(NEG1, POS1);
        expect_flags(1'b0, 1'b0, "R3 codes next to the rails");
    endtask

    task automatic t_left_pos();
        sample(POS, MID);
        sample(POS, MID);
        expect_flags(1'b1, 1'b0, "R1 R3 left positive rail pair");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4095; i++) lr_tick();
        expect_flags(1'b1, 1'b0, "R4 high after 4095 periods");
        lrck = 1'b1; @(negedge clk);
        expect_flags(1'b0, 1'b0, "R4 low after 4096th edge");
        lrck = 1'b0; @(negedge clk);
    endtask

    task automatic t_right_neg();
        sample(MID, NEG);
        sample(MID, NEG);
        expect_flags(1'b0, 1'b1, "R1 R3 right negative rail pair");
    endtask

    task automatic t_power_down();
        sample(POS, NEG);
        sample(POS, NEG);
        expect_flags(1'b1, 1'b1, "R2 both channels raised");
        pwr_dn = 1'b1; @(negedge clk);
        expect_flags(1'b0, 1'b0, "R7 forced low in power-down");
        sample(POS, NEG);
        sample(POS, NEG);
        expect_flags(1'b0, 1'b0, "R7 words ignored in power-down");
        pwr_dn = 1'b0; @(negedge clk);
        expect_flags(1'b0, 1'b0, "R7 low after release");
        sample(POS, NEG);
        expect_flags(1'b0, 1'b0, "R7 detection state discarded");
        sample(MID, MID);
    endtask

    task automatic t_retrigger();
        sample(POS, MID);
        sample(POS, MID);
        for (int i = 0; i < 2000; i++) lr_tick();
        sample(MID, MID);
        sample(POS, MID);
        sample(POS, MID);
        for (int i = 0; i < 4095; i++) lr_tick();
        expect_flags(1'b1, 1'b0, "R5 reloaded hold still high");
        lr_tick();
        expect_flags(1'b0, 1'b0, "R5 low after full reload");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_strobe();
        t_single_and_break();
        t_near_rail();
        t_left_pos();
        t_hold();
        t_right_neg();
        clear_all();
        t_power_down();
        t_retrigger();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule